// File: doc/BRIEF.md
# LPC host cycle generator

This block is the host end of a Low Pin Count bus. A client hands it one transfer at a time on a parallel request port: the cycle kind (I/O, memory, firmware memory or DMA), the direction, an address, a size of one, two or four bytes, and the write data. The block then runs the whole bus cycle on its own. It frames the cycle with the start strobe and sends the header nibbles. It sends or collects the data nibbles and turns the bus around in both directions. It waits through the synchronisation nibbles that the peripheral returns.

At the end it pulses a done strobe together with a two-bit status: 0 for success, 1 for a peripheral error, 2 for a timeout, 3 for a firmware-write protocol violation. Read data appears on a 32-bit port. Firmware bursts move all bytes back to back under one synchronisation phase. The other kinds repeat the synchronisation phase for every byte. A programmable watchdog ends a cycle whose peripheral never finishes waiting, and the bus is aborted when it fires.

Top module: `lpc_host_seq`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` is high and `busy` is low. `busy` then stays high until the cycle ends. Request inputs that change while `busy` is high have no effect on the bus sequence or on the results.
- R2: Each cycle begins with one clock of `lframe_n` low carrying a start nibble: 4'hE for a firmware write, 4'hD for a firmware read, and 4'h0 otherwise. The next clock carries the type nibble: I/O 4'h0 (read) or 4'h2 (write), memory 4'h4 or 4'h6, DMA 4'h8 or 4'hA, and firmware 4'h0 (device select).
- R3: Address nibbles follow, most significant first. I/O sends 4 nibbles (addr[15:0]), memory 8, firmware 7 (addr[27:0]), and DMA sends 1 nibble (addr[3:0]) as the channel. Only firmware and DMA cycles then add a size nibble. `req_size` 0, 1 and 2 select 1, 2 and 4 bytes. The size nibble is 0, 1 and 2 for firmware, and 0, 1 and 3 for DMA.
- R4: When the host hands the bus over, it drives 4'hF for one clock and then releases LAD (`lad_oe` low) for one clock. When the peripheral hands the bus back, the host keeps LAD released for two clocks.
- R5: Data moves one nibble per clock, low nibble of each byte first. Bytes go in ascending order, and byte k occupies bits 8k+7..8k of `req_wdata` and of `rdata`.
- R6: A firmware cycle moves all bytes consecutively around a single synchronisation phase. A non-firmware write repeats data, host turnaround, synchronisation and peripheral turnaround for each byte. A non-firmware read repeats synchronisation and data for each byte.
- R7: During a synchronisation phase, codes 4'h0 (ready) and 4'h9 (ready with more) complete the byte. Any other code except 4'hA is a wait, and LAD is sampled again on the next clock. A multi-byte DMA transfer that answers 4'h9 between bytes completes normally.
- R8: A firmware write has a single synchronisation clock. Any code there other than 4'h0 or 4'hA ends the cycle with status 3.
- R9: A 4'hA code in a non-firmware cycle abandons the remaining bytes, keeps the two-clock peripheral turnaround and ends with status 1. In a firmware cycle 4'hA counts as ready.
- R10: After `wd_limit` consecutive wait codes in one synchronisation phase (`wd_limit` ≥ 1), the host drives `lframe_n` low with LAD 4'hF for four clocks and ends with status 2. One wait fewer than `wd_limit` does not abort.
- R11: `done` is high for exactly one clock, which is the first idle clock after the cycle. `sts` is valid with it. `rdata` is cleared when a request is taken, holds the read bytes received so far, and does not change while the block is idle.
- R12: After reset the block is idle. `lframe_n` is high, `lad_oe` low, `done` low, and `sts` and `rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 I/O, 1 memory, 2 firmware, 3 DMA |
| req_write | input | 1 | 1 = host sends data |
| req_addr | input | 32 | Address, or DMA channel in [3:0] |
| req_size | input | 2 | 0/1/2 = 1/2/4 bytes |
| req_wdata | input | 32 | Write data |
| wd_limit | input | WD_W | Wait codes tolerated per synchronisation phase |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle strobe |
| sts | output | 2 | 0 ok, 1 error, 2 timeout, 3 violation |
| rdata | output | 32 | Read data |
| lframe_n | output | 1 | Active-low frame strobe |
| lad_out | output | 4 | LAD value driven by the host |
| lad_oe | output | 1 | LAD output enable |
| lad_in | input | 4 | LAD value sampled from the bus |

## Verification
The bench targets the points where the cycle kinds diverge, as listed below:
- A firmware burst that took a synchronisation phase per byte would stall on nibbles the bench never sends.
- A design that treated an error code in a firmware read as an error would report status 1 where 0 is expected.
- An error in the first byte of a two-byte write tests abandonment. A design that kept going would send a third data nibble where the bench expects the bus released.
- The watchdog is driven exactly at its limit and one wait below it. An off-by-one counter would abort a legal cycle or miss the abort.
- A firmware write answered with a wait code must report a violation.
- A request held active with changing fields during a cycle must leave the bus sequence untouched.

// File: rtl/lpc_host_seq.sv
module lpc_host_seq #(
  parameter int WD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic            req_write,
  input  logic [31:0]     req_addr,
  input  logic [1:0]      req_size,
  input  logic [31:0]     req_wdata,
  input  logic [WD_W-1:0] wd_limit,
  output logic            busy,
  output logic            done,
  output logic [1:0]      sts,
  output logic [31:0]     rdata,
  output logic            lframe_n,
  output logic [3:0]      lad_out,
  output logic            lad_oe,
  input  logic [3:0]      lad_in
);

  localparam logic [1:0] K_IO = 2'd0, K_MEM = 2'd1, K_FW = 2'd2, K_DMA = 2'd3;
  localparam logic [1:0] ST_OK = 2'd0, ST_ERR = 2'd1, ST_TMO = 2'd2, ST_VIOL = 2'd3;
  localparam logic [3:0] SY_RDY = 4'h0, SY_MORE = 4'h9, SY_ERR = 4'hA;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_CTYP, S_ADDR, S_SIZE, S_HDAT, S_HTA1, S_HTA2,
    S_SYNC, S_FWS, S_PDAT, S_PTA1, S_PTA2, S_ABRT
  } st_t;

  st_t            state;
  logic [1:0]     kind, size;
  logic           wr, fin;
  logic [31:0]    addr, wdat;
  logic [2:0]     ac;
  logic [3:0]     dn;
  logic [1:0]     abc;
  logic [WD_W-1:0] wcnt;

  logic           fw, dma;
  logic [2:0]     amax;
  logic [31:0]    ash;
  logic [3:0]     nib_tot, nib_last, szc, ctyp, startn;
  logic           sy_end, sy_err;

  assign fw       = kind == K_FW;
  assign dma      = kind == K_DMA;
  assign nib_tot  = (size == 2'd0) ? 4'd2 : (size == 2'd1) ? 4'd4 : 4'd8;
  assign nib_last = nib_tot - 4'd1;
  assign szc      = (size == 2'd0) ? 4'h0 : (size == 2'd1) ? 4'h1 : (fw ? 4'h2 : 4'h3);
  assign startn   = fw ? (wr ? 4'hE : 4'hD) : 4'h0;
  assign ash      = addr >> {amax - ac, 2'b00};
  assign sy_err   = (lad_in == SY_ERR) && !fw;
  assign sy_end   = (lad_in == SY_RDY) || (lad_in == SY_MORE) || ((lad_in == SY_ERR) && fw);

  always_comb begin
    case (kind)
      K_IO:    begin amax = 3'd3; ctyp = {3'b000, wr} << 1; end
      K_MEM:   begin amax = 3'd7; ctyp = {2'b01, wr, 1'b0}; end
      K_FW:    begin amax = 3'd6; ctyp = 4'h0; end
      default: begin amax = 3'd0; ctyp = {2'b10, wr, 1'b0}; end
    endcase
  end

  assign busy     = state != S_IDLE;
  assign lframe_n = !(state == S_START || state == S_ABRT);
  assign lad_oe   = state inside {S_START, S_CTYP, S_ADDR, S_SIZE, S_HDAT, S_HTA1, S_ABRT};

  always_comb begin
    case (state)
      S_START: lad_out = startn;
      S_CTYP:  lad_out = ctyp;
      S_ADDR:  lad_out = ash[3:0];
      S_SIZE:  lad_out = szc;
      S_HDAT:  lad_out = wdat[{dn[2:0], 2'b00} +: 4];
      default: lad_out = 4'hF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      kind  <= K_IO;
      size  <= 2'd0;
      wr    <= 1'b0;
      addr  <= '0;
      wdat  <= '0;
      ac    <= '0;
      dn    <= '0;
      abc   <= '0;
      wcnt  <= '0;
      fin   <= 1'b0;
      done  <= 1'b0;
      sts   <= ST_OK;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          kind  <= req_kind;
          size  <= req_size;
          wr    <= req_write;
          addr  <= req_addr;
          wdat  <= req_wdata;
          ac    <= '0;
          dn    <= '0;
          wcnt  <= '0;
          fin   <= 1'b0;
          sts   <= ST_OK;
          rdata <= '0;
          state <= S_START;
        end
        S_START: state <= S_CTYP;
        S_CTYP:  state <= S_ADDR;
        S_ADDR: begin
          ac <= ac + 3'd1;
          if (ac == amax)
            state <= (fw || dma) ? S_SIZE : (wr ? S_HDAT : S_HTA1);
        end
        S_SIZE: state <= wr ? S_HDAT : S_HTA1;
        S_HDAT: begin
          dn <= dn + 4'd1;
          if (dn[0] && (!fw || dn == nib_last)) state <= S_HTA1;
        end
        S_HTA1: state <= S_HTA2;
        S_HTA2: begin
          wcnt  <= '0;
          state <= (fw && wr) ? S_FWS : S_SYNC;
        end
        S_SYNC: begin
          if (sy_err) begin
            sts   <= ST_ERR;
            fin   <= 1'b1;
            state <= S_PTA1;
          end else if (sy_end) begin
            if (wr) begin
              fin   <= dn == nib_tot;
              state <= S_PTA1;
            end else
              state <= S_PDAT;
          end else if (wcnt == wd_limit - 1'b1) begin
            sts   <= ST_TMO;
            abc   <= '0;
            state <= S_ABRT;
          end else
            wcnt <= wcnt + 1'b1;
        end
        S_FWS: begin
          if (lad_in != SY_RDY && lad_in != SY_ERR) sts <= ST_VIOL;
          fin   <= 1'b1;
          state <= S_PTA1;
        end
        S_PDAT: begin
          rdata[{dn[2:0], 2'b00} +: 4] <= lad_in;
          dn <= dn + 4'd1;
          if (dn[0]) begin
            if (dn == nib_last) begin
              fin   <= 1'b1;
              state <= S_PTA1;
            end else if (!fw) begin
              wcnt  <= '0;
              state <= S_SYNC;
            end
          end
        end
        S_PTA1: state <= S_PTA2;
        S_PTA2: begin
          if (fin) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else
            state <= S_HDAT;
        end
        S_ABRT: begin
          abc <= abc + 2'd1;
          if (abc == 2'd3) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_frame_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!lframe_n && $past(lframe_n) && !$past(busy)) |-> $past(req_valid));

  p_release_after_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lad_oe) |-> $past(lad_out) == 4'hF);

  p_fw_never_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == K_FW) |-> sts != ST_ERR);

  p_wd_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SYNC && wd_limit != '0) |-> wcnt < wd_limit);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(rdata));

endmodule

// File: tb/tb_lpc_host_seq.sv
module tb_lpc_host_seq;
  localparam int CLK_NS = 10;
  localparam logic [1:0] K_IO = 2'd0, K_MEM = 2'd1, K_FW = 2'd2, K_DMA = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_kind = '0, req_size = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [15:0] wd_limit = 16'd8;
  logic busy, done, lframe_n, lad_oe;
  logic [1:0] sts;
  logic [31:0] rdata;
  logic [3:0] lad_out, lad_in = 4'hF;

  int nchk = 0, nfail = 0;
  bit finished = 0;
  int waits [4];
  logic [3:0] term [4];
  logic [3:0] fwc;

  always #(CLK_NS/2) clk = ~clk;

  lpc_host_seq #(.WD_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .wd_limit(wd_limit), .busy(busy), .done(done),
    .sts(sts), .rdata(rdata), .lframe_n(lframe_n), .lad_out(lad_out),
    .lad_oe(lad_oe), .lad_in(lad_in));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_nib(input logic [3:0] v, input logic fr, input string tag);
    chk(tag, {26'd0, lframe_n, lad_oe, lad_out}, {26'd0, fr, 1'b1, v});
    @(negedge clk);
  endtask

  task automatic per_nib(input logic [3:0] v, input string tag);
    chk(tag, {30'd0, lframe_n, lad_oe}, 32'd2);
    lad_in = v;
    @(negedge clk);
  endtask

  function automatic logic [3:0] exp_ctyp(input logic [1:0] k, input bit w);
    case (k)
      K_IO:    return w ? 4'h2 : 4'h0;
      K_MEM:   return w ? 4'h6 : 4'h4;
      K_DMA:   return w ? 4'hA : 4'h8;
      default: return 4'h0;
    endcase
  endfunction

  function automatic int exp_alen(input logic [1:0] k);
    case (k)
      K_IO: return 4;
      K_MEM: return 8;
      K_FW: return 7;
      default: return 1;
    endcase
  endfunction

  // res: 0 completed, 1 error, 2 timeout (abort already checked)
  task automatic sync_phase(input int b, input bit isfw, output int res);
    res = 0;
    for (int i = 0; i < waits[b] && i < wd_limit; i++)
      per_nib(($urandom % 2) ? 4'h5 : 4'h6, "R7 wait");
    if (waits[b] >= wd_limit) begin
      res = 2;
      for (int i = 0; i < 4; i++) host_nib(4'hF, 1'b0, "R10 abort");
      return;
    end
    per_nib(term[b], "R7 sync end");
    if (term[b] == 4'hA && !isfw) res = 1;
  endtask

  task automatic run_txn(input logic [1:0] k, input bit w, input logic [31:0] a,
                         input logic [1:0] sz, input logic [31:0] d, input bit noise);
    int nb, alen, res;
    logic [1:0] est;
    logic [31:0] erd, rd0;
    logic [3:0] v;
    bit isfw;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    alen = exp_alen(k);
    isfw = (k == K_FW);
    est = 2'd0; erd = '0; res = 0;
    req_kind = k; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
    req_valid = 1'b1;
    @(negedge clk);
    if (noise) begin
      req_kind = 2'($urandom); req_write = 1'($urandom); req_addr = $urandom;
      req_size = 2'($urandom); req_wdata = $urandom;
      chk("R1 busy", {31'd0, busy}, 32'd1);
    end else
      req_valid = 1'b0;
    host_nib(isfw ? (w ? 4'hE : 4'hD) : 4'h0, 1'b0, "R2 start");
    host_nib(exp_ctyp(k, w), 1'b1, "R2 type");
    for (int i = 0; i < alen; i++) host_nib(4'((a >> (4 * (alen - 1 - i))) & 32'hF), 1'b1, "R3 addr");
    if (isfw || k == K_DMA)
      host_nib((sz == 0) ? 4'h0 : (sz == 1) ? 4'h1 : (isfw ? 4'h2 : 4'h3), 1'b1, "R3 size");
    if (w) begin
      if (isfw) begin
        for (int n = 0; n < 2 * nb; n++) host_nib(d[4*n +: 4], 1'b1, "R6 fw burst");
        host_nib(4'hF, 1'b1, "R4 tar");
        per_nib(4'hF, "R4 release");
        per_nib(fwc, "R8 fw sync");
        if (fwc != 4'h0 && fwc != 4'hA) est = 2'd3;
        per_nib(4'hF, "R4 ptar"); per_nib(4'hF, "R4 ptar");
      end else begin
        for (int b = 0; b < nb; b++) begin
          host_nib(d[8*b +: 4], 1'b1, "R5 lo nibble");
          host_nib(d[8*b+4 +: 4], 1'b1, "R5 hi nibble");
          host_nib(4'hF, 1'b1, "R4 tar");
          per_nib(4'hF, "R4 release");
          sync_phase(b, 1'b0, res);
          if (res == 2) break;
          per_nib(4'hF, "R6 ptar"); per_nib(4'hF, "R6 ptar");
          if (res == 1) break;
        end
      end
    end else begin
      host_nib(4'hF, 1'b1, "R4 tar");
      per_nib(4'hF, "R4 release");
      if (isfw) begin
        sync_phase(0, 1'b1, res);
        if (res != 2) begin
          for (int n = 0; n < 2 * nb; n++) begin
            v = 4'($urandom); erd[4*n +: 4] = v;
            per_nib(v, "R6 fw read");
          end
        end
      end else begin
        for (int b = 0; b < nb; b++) begin
          sync_phase(b, 1'b0, res);
          if (res != 0) break;
          for (int j = 0; j < 2; j++) begin
            v = 4'($urandom); erd[8*b + 4*j +: 4] = v;
            per_nib(v, "R6 read byte");
          end
        end
      end
      if (res != 2) begin per_nib(4'hF, "R4 ptar"); per_nib(4'hF, "R4 ptar"); end
    end
    if (res == 1) est = 2'd1;
    if (res == 2) est = 2'd2;
    req_valid = 1'b0;
    chk("R11 done", {31'd0, done}, 32'd1);
    chk(est == 1 ? "R9 status" : est == 2 ? "R10 status" : est == 3 ? "R8 status" : "R7 status",
        {30'd0, sts}, {30'd0, est});
    chk("R5 rdata", rdata, erd);
    rd0 = rdata;
    @(negedge clk);
    chk("R11 done drop", {31'd0, done}, 32'd0);
    chk("R11 rdata hold", rdata, rd0);
  endtask

  task automatic set_sync(input int w0, input logic [3:0] t0, input int w1, input logic [3:0] t1,
                          input int w2, input logic [3:0] t2, input int w3, input logic [3:0] t3);
    waits[0] = w0; term[0] = t0; waits[1] = w1; term[1] = t1;
    waits[2] = w2; term[2] = t2; waits[3] = w3; term[3] = t3;
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    fwc = 4'h0;
    repeat (3) @(negedge clk);
    chk("R12 reset frame/oe", {30'd0, lframe_n, lad_oe}, 32'd2);
    chk("R12 reset done/sts", {29'd0, done, sts}, 32'd0);
    chk("R12 reset rdata", rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 idle", {31'd0, busy}, 32'd0);

    set_sync(0, 4'h0, 0, 4'h0, 0, 4'h0, 0, 4'h0);
    run_txn(K_IO, 1'b1, 32'h0000_12A4, 2'd0, 32'h0000_00C3, 1'b0);
    set_sync(2, 4'h0, 0, 4'h0, 0, 4'h0, 0, 4'h0);
    run_txn(K_MEM, 1'b0, 32'hDEAD_BEEF, 2'd0, 32'h0, 1'b0);
    fwc = 4'h5;
    run_txn(K_FW, 1'b1, 32'h0ABC_DEF1, 2'd2, 32'h8765_4321, 1'b0);
    fwc = 4'hA;
    run_txn(K_FW, 1'b1, 32'h0123_4567, 2'd1, 32'h0000_5AA5, 1'b0);
    fwc = 4'h0;
    set_sync(1, 4'hA, 0, 4'h0, 0, 4'h0, 0, 4'h0);
    run_txn(K_FW, 1'b0, 32'h0765_4321, 2'd1, 32'h0, 1'b0);
    set_sync(0, 4'h9, 1, 4'h9, 0, 4'h9, 2, 4'h0);
    run_txn(K_DMA, 1'b0, 32'h0000_0005, 2'd2, 32'h0, 1'b0);
    run_txn(K_DMA, 1'b1, 32'h0000_0003, 2'd2, 32'hCAFE_F00D, 1'b0);
    set_sync(0, 4'hA, 0, 4'h0, 0, 4'h0, 0, 4'h0);
    run_txn(K_IO, 1'b1, 32'h0000_0080, 2'd1, 32'h0000_BEEF, 1'b0);
    set_sync(0, 4'h0, 1, 4'hA, 0, 4'h0, 0, 4'h0);
    run_txn(K_MEM, 1'b0, 32'h1000_0000, 2'd2, 32'h0, 1'b0);
    wd_limit = 16'd3;
    set_sync(0, 4'h0, 3, 4'h0, 0, 4'h0, 0, 4'h0);
    run_txn(K_MEM, 1'b0, 32'h2000_0040, 2'd2, 32'h0, 1'b0);
    set_sync(2, 4'h0, 0, 4'h0, 0, 4'h0, 0, 4'h0);
    run_txn(K_IO, 1'b0, 32'h0000_0060, 2'd0, 32'h0, 1'b0);
    set_sync(3, 4'h0, 0, 4'h0, 0, 4'h0, 0, 4'h0);
    run_txn(K_DMA, 1'b1, 32'h0000_0002, 2'd1, 32'h0000_1234, 1'b0);
    wd_limit = 16'd8;
    set_sync(1, 4'h0, 0, 4'h0, 0, 4'h0, 0, 4'h0);
    run_txn(K_MEM, 1'b1, 32'h3000_0010, 2'd0, 32'h0000_0077, 1'b1);

    for (int t = 0; t < 60; t++) begin
      logic [1:0] k, sz;
      bit w;
      int r;
      k = 2'($urandom); w = 1'($urandom); sz = 2'($urandom % 3);
      for (int b = 0; b < 4; b++) begin
        waits[b] = $urandom % 4;
        r = $urandom % 10;
        term[b] = (r < 6) ? 4'h0 : (r < 9) ? 4'h9 : 4'hA;
      end
      r = $urandom % 6;
      fwc = (r < 4) ? 4'h0 : (r == 4) ? 4'hA : 4'h6;
      run_txn(k, w, $urandom, sz, $urandom, 1'($urandom % 4 == 0));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule